// File: doc/BRIEF.md
# Processor Supervisor Reset and Watchdog Core

This block is the digital half of a processor supervisor. Comparators outside it turn the supply, the backup battery and a power-fail sense input into three digital flags. The core combines those flags with a three-level watchdog code and a chip-enable input. From them it produces the system reset in both polarities, a low-line flag, a watchdog status output, a battery-on flag, a power-fail output and a gated chip-enable for a memory that must not be written while the supply is collapsing.

The reset stretch and the watchdog period are counted in ticks of a single-cycle enable from a prescaler outside the block. `RST_TICKS` and `WD_TICKS` set the two periods. The watchdog input is a 2-bit code: a held level that outlasts the period produces a fresh reset pulse. Either edge of the level counts as service. A floating code turns the watchdog off.

Top module: `supervisor_core`

## Requirements
- R1: `sys_rst_n_o` is low whenever the synchronized `vcc_low_i` or `vcc_lt_batt_i` flag is high. Each flag input passes through two flops, so its effect appears after two clock edges. Reset is also low while `rst_n` is asserted.
- R2: After both supply flags clear, `sys_rst_n_o` stays low for exactly `RST_TICKS` tick pulses and rises on the last one.
- R3: `sys_rst_o` is at all times the inverse of `sys_rst_n_o`.
- R4: `low_line_n_o` is low when either synchronized supply flag is high, and high otherwise.
- R5: The watchdog code on `wdi_code_i` is 2'b00 for level low, 2'b01 for level high, and 2'b10 or 2'b11 for floating. If an enabled level is held for `WD_TICKS` ticks with no edge, `wdo_n_o` goes low and a reset pulse of `RST_TICKS` ticks starts. With fewer than `WD_TICKS` ticks there is no timeout.
- R6: A rising edge and a falling edge of the watchdog level both restart the timeout count from zero.
- R7: While the watchdog stays unserviced, a new reset pulse starts every `WD_TICKS` ticks, and reset is released between pulses.
- R8: A floating watchdog code disables the timer. Any number of ticks then produces neither a timeout nor a reset.
- R9: `wdo_n_o` returns high one cycle after a watchdog edge is detected, or one cycle after the low-line condition appears.
- R10: `ce_out_n_o` equals `ce_in_n_i` while the synchronized `vcc_low_i` is low, and is forced high while it is high.
- R11: `batt_on_o` equals the synchronized `vcc_lt_batt_i`. `pfo_n_o` is low while that flag is high; otherwise it is the inverse of the synchronized `pfi_low_i`.
- R12: The watchdog count is held at zero while either supply flag is high. After recovery, a timeout takes a full `WD_TICKS` ticks counted from the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle prescaled time base enable |
| vcc_low_i | input | 1 | Supply below reset threshold flag |
| vcc_lt_batt_i | input | 1 | Supply below backup battery flag |
| pfi_low_i | input | 1 | Power-fail sense below reference flag |
| wdi_code_i | input | 2 | Watchdog code: 00 low, 01 high, 1x floating |
| ce_in_n_i | input | 1 | Active-low chip-enable request |
| sys_rst_n_o | output | 1 | Active-low system reset |
| sys_rst_o | output | 1 | Active-high system reset |
| low_line_n_o | output | 1 | Low when the supply is failing |
| wdo_n_o | output | 1 | Low after a watchdog timeout |
| batt_on_o | output | 1 | High while running from battery |
| pfo_n_o | output | 1 | Power-fail output, low on power fail |
| ce_out_n_o | output | 1 | Gated active-low chip-enable |

## Verification
All sixteen combinations of the three supply flags and the chip-enable input are swept. Together they separate the threshold flag from the battery flag in the chip-enable, power-fail and low-line outputs. The watchdog is held at each level for every count from one tick up to the period, which finds an off-by-one in the timeout compare. Repeated near-timeout holds broken by rising and falling edges show that both edges restart the count. Long unserviced holds, long floating intervals and holds across a supply dip tell periodic pulses apart from a disabled timer and from a count that was not cleared during low supply.

// File: rtl/sup_pkg.sv
package sup_pkg;
   typedef enum logic [1:0] {
      WDI_LOW   = 2'b00,
      WDI_HIGH  = 2'b01,
      WDI_FLOAT = 2'b10
   } wdi_code_e;

   function automatic logic wdi_enabled(input logic [1:0] code);
      return ~code[1];
   endfunction

   function automatic logic wdi_level(input logic [1:0] code);
      return code[0];
   endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int unsigned        W       = 1,
   parameter int unsigned        STAGES  = 2,
   parameter logic [W-1:0]       RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sup_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
   import sup_pkg::*;
#(
   parameter int unsigned WD_TICKS = 1600,
   localparam int unsigned CW      = $clog2(WD_TICKS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       hold_clr,
   input  logic [1:0] code,
   output logic       kick,
   output logic       fire,
   output logic       wdo_n
);
   logic          en, lvl, en_q, lvl_q, run;
   logic [CW-1:0] cnt;

   assign en   = wdi_enabled(code);
   assign lvl  = wdi_level(code);
   assign kick = en & en_q & (lvl ^ lvl_q);
   assign run  = en & ~hold_clr;
   assign fire = run & ~kick & tick & (cnt == CW'(WD_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         lvl_q <= 1'b0;
      end else begin
         en_q  <= en;
         lvl_q <= lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || kick) cnt <= '0;
      else if (fire)         cnt <= '0;
      else if (tick)         cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wdo_n <= 1'b1;
      else if (kick || hold_clr) wdo_n <= 1'b1;
      else if (fire)             wdo_n <= 1'b0;
   end
endmodule

// File: rtl/sup_rstgen.sv
module sup_rstgen #(
   parameter int unsigned RST_TICKS = 140,
   localparam int unsigned CW       = $clog2(RST_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic supply_fail,
   input  logic fire,
   output logic active
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (supply_fail || fire) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active && tick) begin
         if (cnt == CW'(RST_TICKS - 1)) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/supervisor_core.sv
module supervisor_core
   import sup_pkg::*;
#(
   parameter int unsigned RST_TICKS   = 140,
   parameter int unsigned WD_TICKS    = 1600,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       vcc_low_i,
   input  logic       vcc_lt_batt_i,
   input  logic       pfi_low_i,
   input  logic [1:0] wdi_code_i,
   input  logic       ce_in_n_i,
   output logic       sys_rst_n_o,
   output logic       sys_rst_o,
   output logic       low_line_n_o,
   output logic       wdo_n_o,
   output logic       batt_on_o,
   output logic       pfo_n_o,
   output logic       ce_out_n_o
);
   localparam int unsigned NFLAG = 3;

   if (RST_TICKS < 1) begin : g_bad_rst
      $error("supervisor_core: RST_TICKS must be at least 1");
   end
   if (WD_TICKS <= RST_TICKS) begin : g_bad_wd
      $error("supervisor_core: WD_TICKS must exceed RST_TICKS");
   end

   logic [NFLAG-1:0] flag_s;
   logic [1:0]       wdi_s;
   logic             vcc_low_s, lt_batt_s, pfi_low_s, supply_fail;
   logic             wd_kick, wd_fire, pulse_active;

   sup_sync #(.W(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL({NFLAG{1'b1}})) u_flag_sync (
      .clk(clk), .rst_n(rst_n),
      .d({pfi_low_i, vcc_lt_batt_i, vcc_low_i}), .q(flag_s)
   );

   sup_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(WDI_FLOAT)) u_wdi_sync (
      .clk(clk), .rst_n(rst_n), .d(wdi_code_i), .q(wdi_s)
   );

   assign vcc_low_s   = flag_s[0];
   assign lt_batt_s   = flag_s[1];
   assign pfi_low_s   = flag_s[2];
   assign supply_fail = vcc_low_s | lt_batt_s;

   sup_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hold_clr(supply_fail),
      .code(wdi_s), .kick(wd_kick), .fire(wd_fire), .wdo_n(wdo_n_o)
   );

   sup_rstgen #(.RST_TICKS(RST_TICKS)) u_rstgen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .supply_fail(supply_fail),
      .fire(wd_fire), .active(pulse_active)
   );

   assign sys_rst_n_o  = ~(supply_fail | pulse_active);
   assign sys_rst_o    = ~sys_rst_n_o;
   assign low_line_n_o = ~supply_fail;
   assign batt_on_o    = lt_batt_s;
   assign pfo_n_o      = ~lt_batt_s & ~pfi_low_s;
   assign ce_out_n_o   = vcc_low_s | ce_in_n_i;
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
   input logic clk,
   input logic rst_n,
   input logic sys_rst_n,
   input logic sys_rst,
   input logic low_line_n,
   input logic batt_on,
   input logic pfo_n,
   input logic ce_out_n,
   input logic vcc_low_s,
   input logic kick,
   input logic fire,
   input logic wdo_n
);
   AST_RST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst == !sys_rst_n); // R3
   AST_LOWLINE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !low_line_n |-> !sys_rst_n); // R1
   AST_CE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_low_s |-> ce_out_n); // R10
   AST_PFO_ON_BATT: assert property (@(posedge clk) disable iff (!rst_n)
      batt_on |-> !pfo_n); // R11
   AST_FIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (!sys_rst_n && !wdo_n)); // R5
   AST_KICK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> wdo_n); // R9
   AST_LOWLINE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      !low_line_n |=> wdo_n); // R9
   AST_NO_FIRE_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !low_line_n |-> !fire); // R12
endmodule

bind supervisor_core sup_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n_o), .sys_rst(sys_rst_o),
   .low_line_n(low_line_n_o), .batt_on(batt_on_o), .pfo_n(pfo_n_o),
   .ce_out_n(ce_out_n_o), .vcc_low_s(vcc_low_s), .kick(wd_kick),
   .fire(wd_fire), .wdo_n(wdo_n_o)
);

// File: tb/supervisor_core_tb.sv
`timescale 1ns/1ps
module supervisor_core_tb;
   localparam int RST = 3;
   localparam int WD  = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       vlow = 1'b0, vbatt = 1'b0, pfil = 1'b0, ce_n = 1'b1;
   logic [1:0] wdi = 2'b10;
   logic       sys_rst_n, sys_rst, low_line_n, wdo_n, batt_on, pfo_n, ce_out_n;
   logic       lvl = 1'b0;
   int         n_chk = 0, n_fail = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   supervisor_core #(.RST_TICKS(RST), .WD_TICKS(WD)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_low_i(vlow),
      .vcc_lt_batt_i(vbatt), .pfi_low_i(pfil), .wdi_code_i(wdi),
      .ce_in_n_i(ce_n), .sys_rst_n_o(sys_rst_n), .sys_rst_o(sys_rst),
      .low_line_n_o(low_line_n), .wdo_n_o(wdo_n), .batt_on_o(batt_on),
      .pfo_n_o(pfo_n), .ce_out_n_o(ce_out_n)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic toggle();
      lvl = ~lvl;
      wdi = {1'b0, lvl};
      cyc(3);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      cyc(3);
      // reset state
      chk("R1 reset", sys_rst_n, 1'b0);
      chk("R3 reset", sys_rst, 1'b1);
      chk("R4 reset", low_line_n, 1'b0);
      chk("R10 reset", ce_out_n, 1'b1);
      chk("R9 reset", wdo_n, 1'b1);
      rst_n = 1'b1;
      cyc(1);

      // R4 R10 R11 sweep over the flags and chip-enable
      for (int v = 0; v < 16; v++) begin
         {vlow, vbatt, pfil, ce_n} = v[3:0];
         cyc(3);
         chk("R4 sweep", low_line_n, !(vlow | vbatt));
         chk("R10 sweep", ce_out_n, vlow | ce_n);
         chk("R11 batt_on", batt_on, vbatt);
         chk("R11 pfo", pfo_n, !vbatt & !pfil);
         chk("R1 sweep", sys_rst_n, 1'b0);
         chk("R3 sweep", sys_rst, !sys_rst_n);
      end

      // R2 stretch after recovery
      {vlow, vbatt, pfil, ce_n} = 4'b0000;
      cyc(3);
      ticks(RST - 1);
      chk("R2 held", sys_rst_n, 1'b0);
      ticks(1);
      chk("R2 released", sys_rst_n, 1'b1);
      chk("R3 released", sys_rst, 1'b0);

      // R1 each supply flag alone
      vbatt = 1'b1; cyc(3);
      chk("R1 batt", sys_rst_n, 1'b0);
      chk("R10 batt only", ce_out_n, 1'b0);
      vbatt = 1'b0; cyc(3); ticks(RST);
      chk("R2 after batt", sys_rst_n, 1'b1);
      vlow = 1'b1; cyc(3);
      chk("R1 vlow", sys_rst_n, 1'b0);
      vlow = 1'b0; cyc(3); ticks(RST);
      chk("R2 after vlow", sys_rst_n, 1'b1);

      // R5 hold-length sweep at alternating levels
      lvl = 1'b1; toggle();
      for (int n = 1; n <= WD; n++) begin
         ticks(n);
         chk("R5 wdo", wdo_n, !(n == WD));
         chk("R5 rst", sys_rst_n, !(n == WD));
         toggle();
         chk("R9 edge restores", wdo_n, 1'b1);
         if (n == WD) begin
            ticks(RST);
            chk("R5 pulse length", sys_rst_n, 1'b1);
            toggle();
         end
      end

      // R6 both edge directions restart the count
      for (int k = 0; k < 4; k++) begin
         ticks(WD - 1);
         chk("R6 no timeout", wdo_n, 1'b1);
         toggle();
      end
      ticks(WD - 1);
      chk("R6 final", sys_rst_n, 1'b1);
      toggle();

      // R7 repeated pulses while unserviced
      ticks(WD);
      chk("R7 first pulse", sys_rst_n, 1'b0);
      for (int p = 0; p < 3; p++) begin
         ticks(RST);
         chk("R7 released", sys_rst_n, 1'b1);
         chk("R7 wdo stays low", wdo_n, 1'b0);
         ticks(WD - RST - 1);
         chk("R7 before next", sys_rst_n, 1'b1);
         ticks(1);
         chk("R7 next pulse", sys_rst_n, 1'b0);
      end

      // R9 R12 supply dip during timeout
      vlow = 1'b1; cyc(3);
      chk("R9 lowline restores", wdo_n, 1'b1);
      ticks(2 * WD);
      chk("R12 held during fail", wdo_n, 1'b1);
      vlow = 1'b0; cyc(3);
      ticks(RST);
      chk("R12 released", sys_rst_n, 1'b1);
      ticks(WD - RST - 1);
      chk("R12 full period", wdo_n, 1'b1);
      ticks(1);
      chk("R12 timeout", wdo_n, 1'b0);
      toggle();
      ticks(RST);

      // R8 floating codes disable
      wdi = 2'b10; cyc(3);
      ticks(3 * WD);
      chk("R8 float 10 rst", sys_rst_n, 1'b1);
      chk("R8 float 10 wdo", wdo_n, 1'b1);
      wdi = 2'b11; cyc(3);
      ticks(3 * WD);
      chk("R8 float 11 rst", sys_rst_n, 1'b1);
      chk("R8 float 11 wdo", wdo_n, 1'b1);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end
endmodule